// File: doc/BRIEF.md
# Privileged Address Segment Decoder

This block sorts each 32-bit virtual access into one of five segments, using the current privilege level, the error-level flag and the access direction. Segments that need no translation produce a physical address directly. Segments that go through translation raise a one-cycle request toward the translation lookaside buffer. Accesses the current privilege level may not make are reported as an address error, split into a load flavour and a store flavour.

The decision is taken combinationally from the request and held in one register stage. Every outcome therefore appears exactly one clock after the request cycle. The lowest segment changes role when the error-level flag is set: it becomes an identity window. Two kernel windows of 512 MiB each both fold onto the bottom of the physical space.

Top module: `addr_seg_decoder`

## Requirements
- R1: Outcomes appear on the outputs in the clock cycle after `reqValid` is high. In a cycle that follows one with `reqValid` low, all four outcome flags are low and `physAddr` is zero.
- R2: For every accepted request, exactly one of `physValid`, `tlbReq`, `addrErrLoad` and `addrErrStore` is high.
- R3: With `errLevel` low, an address in 0x00000000..0x7FFFFFFF gives `tlbReq` in every privilege mode, with `physAddr` zero.
- R4: With `errLevel` high, an address in 0x00000000..0x7FFFFFFF gives `physValid` with `physAddr` equal to the address, in every privilege mode and for both reads and writes.
- R5: In kernel mode, an address in 0x80000000..0x9FFFFFFF gives `physValid` with `physAddr` equal to the address minus 0x80000000.
- R6: In kernel mode, an address in 0xA0000000..0xBFFFFFFF gives `physValid` with `physAddr` equal to the address minus 0xA0000000.
- R7: An address in 0x80000000..0xBFFFFFFF in any mode other than kernel gives an address error.
- R8: An address in 0xC0000000..0xDFFFFFFF gives `tlbReq` in supervisor or kernel mode, and an address error otherwise.
- R9: An address in 0xE0000000..0xFFFFFFFF gives `tlbReq` in kernel mode only, and an address error otherwise.
- R10: An address error appears on `addrErrStore` when `isWrite` is 1 and on `addrErrLoad` when `isWrite` is 0.
- R11: `privMode` is encoded as 2'b00 kernel, 2'b01 supervisor and 2'b10 user. The value 2'b11 gets user rights.
- R12: `errLevel` has no effect on addresses of 0x80000000 and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access request present this cycle |
| vaddr | input | 32 | Virtual address |
| privMode | input | 2 | Privilege level (00 kernel, 01 supervisor, 10 user, 11 as user) |
| errLevel | input | 1 | Error-level flag |
| isWrite | input | 1 | 1 for a store, 0 for a load |
| physAddr | output | 32 | Physical address for unmapped outcomes, otherwise zero |
| physValid | output | 1 | Unmapped translation done |
| tlbReq | output | 1 | Mapped access, translation requested |
| addrErrLoad | output | 1 | Disallowed load |
| addrErrStore | output | 1 | Disallowed store |

## Verification
The hardest cases to reach are the segment edges under a privilege that sits on the boundary of access rights. Supervisor mode hitting 0xDFFFFFFF is allowed, while supervisor mode hitting 0xE0000000 is refused. The stimulus therefore walks the first and last word of each segment under all four mode codes, with the error-level flag and the direction both set and cleared. Idle cycles are placed between requests so that stale flags would show up.

// File: rtl/segdec_pkg.sv
package segdec_pkg;

  typedef enum logic [1:0] {
    MODE_KERNEL = 2'b00,
    MODE_SUPER  = 2'b01,
    MODE_USER   = 2'b10,
    MODE_RSVD   = 2'b11
  } privMode_e;

  typedef enum logic [2:0] {
    SEG_LOW,
    SEG_KWIN0,
    SEG_KWIN1,
    SEG_SUPMAP,
    SEG_KMAP
  } seg_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeIdentity;
    logic takeWindow;
    logic takeMapped;
    logic takeError;
    logic errIsStore;
  } ctrlStrobe_t;

endpackage

// File: rtl/segdec_ctrl.sv
module segdec_ctrl
  import segdec_pkg::*;
#(
  parameter int SEG_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [SEG_W-1:0] segBits,
  input  logic [1:0]       privMode,
  input  logic             errLevel,
  input  logic             isWrite,
  output ctrlStrobe_t      strobes,
  output logic             physValid,
  output logic             tlbReq,
  output logic             addrErrLoad,
  output logic             addrErrStore
);

  seg_e seg;
  logic isKernel;
  logic isSuper;

  // top bits pick the segment: 0xx low, 100/101 windows, 110, 111
  always_comb begin
    if (!segBits[SEG_W-1])                  seg = SEG_LOW;
    else if (segBits[SEG_W-2:0] == 2'b00)   seg = SEG_KWIN0;
    else if (segBits[SEG_W-2:0] == 2'b01)   seg = SEG_KWIN1;
    else if (segBits[SEG_W-2:0] == 2'b10)   seg = SEG_SUPMAP;
    else                                    seg = SEG_KMAP;
  end

  assign isKernel = (privMode == MODE_KERNEL);
  assign isSuper  = (privMode == MODE_SUPER);

  always_comb begin
    strobes = '0;
    strobes.errIsStore = isWrite;
    if (reqValid) begin
      unique case (seg)
        SEG_LOW: begin
          if (errLevel) strobes.takeIdentity = 1'b1;
          else          strobes.takeMapped   = 1'b1;
        end
        SEG_KWIN0, SEG_KWIN1: begin
          if (isKernel) strobes.takeWindow = 1'b1;
          else          strobes.takeError  = 1'b1;
        end
        SEG_SUPMAP: begin
          if (isKernel || isSuper) strobes.takeMapped = 1'b1;
          else                     strobes.takeError  = 1'b1;
        end
        default: begin
          if (isKernel) strobes.takeMapped = 1'b1;
          else          strobes.takeError  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      physValid    <= 1'b0;
      tlbReq       <= 1'b0;
      addrErrLoad  <= 1'b0;
      addrErrStore <= 1'b0;
    end else begin
      physValid    <= strobes.takeIdentity | strobes.takeWindow;
      tlbReq       <= strobes.takeMapped;
      addrErrLoad  <= strobes.takeError & ~strobes.errIsStore;
      addrErrStore <= strobes.takeError & strobes.errIsStore;
    end
  end

endmodule

// File: rtl/segdec_datapath.sv
module segdec_datapath
  import segdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] vaddr,
  input  ctrlStrobe_t       strobes,
  output logic [ADDR_W-1:0] physAddr
);

  localparam int OFS_W = ADDR_W - SEG_W;

  logic [ADDR_W-1:0] windowAddr;
  logic [ADDR_W-1:0] nextAddr;

  // both kernel windows fold onto the bottom of physical space
  assign windowAddr = {{SEG_W{1'b0}}, vaddr[OFS_W-1:0]};

  always_comb begin
    nextAddr = '0;
    if (strobes.takeIdentity)    nextAddr = vaddr;
    else if (strobes.takeWindow) nextAddr = windowAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) physAddr <= '0;
    else       physAddr <= nextAddr;
  end

endmodule

// File: rtl/addr_seg_decoder.sv
module addr_seg_decoder
  import segdec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        privMode,
  input  logic              errLevel,
  input  logic              isWrite,
  output logic [ADDR_W-1:0] physAddr,
  output logic              physValid,
  output logic              tlbReq,
  output logic              addrErrLoad,
  output logic              addrErrStore
);

  localparam int SEG_W = 3;

  ctrlStrobe_t strobes;

  segdec_ctrl #(.SEG_W(SEG_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .segBits      (vaddr[ADDR_W-1 -: SEG_W]),
    .privMode     (privMode),
    .errLevel     (errLevel),
    .isWrite      (isWrite),
    .strobes      (strobes),
    .physValid    (physValid),
    .tlbReq       (tlbReq),
    .addrErrLoad  (addrErrLoad),
    .addrErrStore (addrErrStore)
  );

  segdec_datapath #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .vaddr    (vaddr),
    .strobes  (strobes),
    .physAddr (physAddr)
  );

endmodule

// File: rtl/segdec_checker.sv
module segdec_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] vaddr,
  input logic [1:0]        privMode,
  input logic              errLevel,
  input logic              isWrite,
  input logic [ADDR_W-1:0] physAddr,
  input logic              physValid,
  input logic              tlbReq,
  input logic              addrErrLoad,
  input logic              addrErrStore
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(reqValid) |-> !(physValid | tlbReq | addrErrLoad | addrErrStore)); // R1

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $past(reqValid) |-> $countones({physValid, tlbReq, addrErrLoad, addrErrStore}) == 1); // R2

  AST_WINDOW_FOLD: assert property (@(posedge clk) disable iff (!rstN)
    (physValid && $past(vaddr[ADDR_W-1])) |-> physAddr[ADDR_W-1 -: 3] == 3'b000); // R5

  AST_NONKERNEL_NO_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    ($past(reqValid) && $past(privMode) != 2'b00 && $past(vaddr[ADDR_W-1])) |-> !physValid); // R7

  AST_STORE_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
    addrErrStore |-> $past(isWrite)); // R10

  AST_LOAD_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
    addrErrLoad |-> !$past(isWrite)); // R10

  AST_LOW_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(reqValid) && !$past(vaddr[ADDR_W-1])) |-> !(addrErrLoad | addrErrStore)); // R3

endmodule

bind addr_seg_decoder segdec_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .vaddr        (vaddr),
  .privMode     (privMode),
  .errLevel     (errLevel),
  .isWrite      (isWrite),
  .physAddr     (physAddr),
  .physValid    (physValid),
  .tlbReq       (tlbReq),
  .addrErrLoad  (addrErrLoad),
  .addrErrStore (addrErrStore)
);

// File: tb/sim_addr_seg_decoder.sv
module sim_addr_seg_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  privMode = '0;
  logic        errLevel = 1'b0;
  logic        isWrite = 1'b0;
  logic [31:0] physAddr;
  logic        physValid, tlbReq, addrErrLoad, addrErrStore;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_seg_decoder u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .vaddr(vaddr),
    .privMode(privMode), .errLevel(errLevel), .isWrite(isWrite),
    .physAddr(physAddr), .physValid(physValid), .tlbReq(tlbReq),
    .addrErrLoad(addrErrLoad), .addrErrStore(addrErrStore)
  );

  // flags packed as {physValid, tlbReq, errLoad, errStore}
  task automatic checkOut(string tag, logic [3:0] expFlags, logic [31:0] expAddr);
    logic [3:0] got;
    got = {physValid, tlbReq, addrErrLoad, addrErrStore};
    checks++;
    if (got !== expFlags || physAddr !== expAddr) begin
      errors++;
      $display("FAIL %s flags=%b addr=%h expected flags=%b addr=%h",
               tag, got, physAddr, expFlags, expAddr);
    end
  endtask

  // apply one request at negedge, check at the following negedge
  task automatic access(string tag, logic [31:0] a, logic [1:0] m, logic e, logic w,
                        logic [3:0] expFlags, logic [31:0] expAddr);
    @(negedge clk);
    reqValid = 1'b1; vaddr = a; privMode = m; errLevel = e; isWrite = w;
    @(negedge clk);
    reqValid = 1'b0;
    checkOut(tag, expFlags, expAddr);
  endtask

  function automatic logic [3:0] errFlags(logic w);
    return w ? 4'b0001 : 4'b0010;
  endfunction

  task automatic testReset();
    @(negedge clk);
    checkOut("R1 reset", 4'b0000, 32'h0);
  endtask

  task automatic testLowMapped();
    for (int m = 0; m < 4; m++) begin
      access("R3 low mapped", 32'h0000_0000, m[1:0], 1'b0, 1'b0, 4'b0100, 32'h0);
      access("R3 low mapped top", 32'h7FFF_FFFF, m[1:0], 1'b0, 1'b1, 4'b0100, 32'h0);
    end
  endtask

  task automatic testLowIdentity();
    for (int m = 0; m < 4; m++) begin
      access("R4 identity", 32'h7FFF_FFFF, m[1:0], 1'b1, m[0], 4'b1000, 32'h7FFF_FFFF);
      access("R4 identity mid", 32'h1234_5678, m[1:0], 1'b1, 1'b1, 4'b1000, 32'h1234_5678);
    end
  endtask

  task automatic testKernelWindows();
    access("R5 win0 base", 32'h8000_0000, 2'b00, 1'b0, 1'b0, 4'b1000, 32'h0);
    access("R5 win0 top", 32'h9FFF_FFFF, 2'b00, 1'b0, 1'b1, 4'b1000, 32'h1FFF_FFFF);
    access("R6 win1 base", 32'hA000_0000, 2'b00, 1'b0, 1'b0, 4'b1000, 32'h0);
    access("R6 win1 mid", 32'hB234_5678, 2'b00, 1'b0, 1'b1, 4'b1000, 32'h1234_5678);
    access("R12 win0 erl", 32'h8765_4321, 2'b00, 1'b1, 1'b0, 4'b1000, 32'h0765_4321);
  endtask

  task automatic testWindowFaults();
    for (int m = 1; m < 4; m++) begin
      access("R7 win0 denied", 32'h8000_0000, m[1:0], 1'b0, 1'b0, errFlags(1'b0), 32'h0);
      access("R7 win1 denied", 32'hBFFF_FFFF, m[1:0], 1'b0, 1'b1, errFlags(1'b1), 32'h0);
    end
  endtask

  task automatic testSuperSeg();
    access("R8 kernel", 32'hC000_0000, 2'b00, 1'b0, 1'b0, 4'b0100, 32'h0);
    access("R8 super top", 32'hDFFF_FFFF, 2'b01, 1'b0, 1'b1, 4'b0100, 32'h0);
    access("R8 user denied", 32'hC000_0000, 2'b10, 1'b0, 1'b1, errFlags(1'b1), 32'h0);
    access("R11 rsvd mode as user", 32'hD000_0000, 2'b11, 1'b0, 1'b0, errFlags(1'b0), 32'h0);
    access("R12 super erl", 32'hC000_0004, 2'b01, 1'b1, 1'b0, 4'b0100, 32'h0);
  endtask

  task automatic testKernelMapped();
    access("R9 kernel base", 32'hE000_0000, 2'b00, 1'b0, 1'b0, 4'b0100, 32'h0);
    access("R9 kernel top", 32'hFFFF_FFFF, 2'b00, 1'b1, 1'b1, 4'b0100, 32'h0);
    access("R9 super denied", 32'hE000_0000, 2'b01, 1'b0, 1'b0, errFlags(1'b0), 32'h0);
    access("R10 user store", 32'hFFFF_FFFF, 2'b10, 1'b0, 1'b1, errFlags(1'b1), 32'h0);
    access("R10 user load", 32'hFFFF_FFFF, 2'b10, 1'b1, 1'b0, errFlags(1'b0), 32'h0);
  endtask

  task automatic testIdleGap();
    access("R2 setup", 32'h8000_0010, 2'b00, 1'b0, 1'b0, 4'b1000, 32'h0000_0010);
    @(negedge clk);
    checkOut("R1 idle after request", 4'b0000, 32'h0);
    // back to back requests
    @(negedge clk);
    reqValid = 1'b1; vaddr = 32'hA000_0100; privMode = 2'b00; errLevel = 1'b0; isWrite = 1'b0;
    @(negedge clk);
    checkOut("R2 b2b first", 4'b1000, 32'h0000_0100);
    vaddr = 32'hE000_0000; privMode = 2'b10; isWrite = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    checkOut("R2 b2b second", 4'b0001, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLowMapped();
    testLowIdentity();
    testKernelWindows();
    testWindowFaults();
    testSuperSeg();
    testKernelMapped();
    testIdleGap();
    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule